// File: doc/BRIEF.md
# Multichannel Sample Gain Scaler

The block sits between sample storage and the serial converters of a multichannel test-waveform source. Every clock cycle it may accept one sample per channel, all flagged by a single valid strobe. Samples are unsigned offset-binary words with mid-scale meaning zero. The block scales each one about mid-scale by a common gain taken from a decimal dial digit. Scaling is a multiply by the digit followed by a divide by ten, rounded toward zero and saturated to the sample range. Because scaling is done about mid-scale, a smaller gain never moves the baseline. The scaled words leave on a two-stage pipeline with their own valid flag.

Attenuation between channels is not done on the data. A second dial digit picks a step size. For each channel the block then issues a 3-bit address for an external switched attenuator, and that address rises with the channel index. With step 1 the addresses are 0, 1, 2, 3, one halving per address, so the first channel is untouched and each later channel has half the amplitude of the one before it.

Top module: `chan_gain_scaler`

## Requirements
- R1: While rst_ni is low, smp_valid_o is 0, every channel of smp_data_o is 16'h8000 and every atten_sel_o field is 0.
- R2: For gain digit g in 0..9 and input sample x, a channel's output is 32768 + trunc((x - 32768) * g / 10), with division rounded toward zero and the result held inside 0..65535. Channel k occupies bits [16k+15:16k] of both data buses.
- R3: A gain digit of 10..15 gives the same result as digit 9.
- R4: smp_valid_o is high in a cycle exactly when smp_valid_i was high two cycles earlier. The data is output in that same cycle, scaled with the gain digit present alongside the input sample.
- R5: A mid-scale input (16'h8000) gives a mid-scale output at every gain, and gain digit 0 gives mid-scale for every input.
- R6: While smp_valid_o is low, smp_data_o keeps the value of the last valid output (16'h8000 if none since reset).
- R7: The attenuator address for channel k (bits [3k+2:3k] of atten_sel_o) is min(k * s, 7), where s = min(atten_bcd_i, 2). It follows a change of atten_bcd_i one cycle later.
- R8: atten_bcd_i has no effect on smp_data_o or smp_valid_o.
- R9: Each channel's output depends only on that channel's own input sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_valid_i | input | 1 | Input samples valid this cycle |
| smp_data_i | input | 64 | Input samples, 16 bits per channel, offset binary |
| gain_bcd_i | input | 4 | Common gain digit (tenths) |
| atten_bcd_i | input | 4 | Inter-channel attenuation step digit |
| smp_valid_o | output | 1 | Scaled samples valid |
| smp_data_o | output | 64 | Scaled samples, 16 bits per channel, offset binary |
| atten_sel_o | output | 12 | Attenuator address, 3 bits per channel |

## Verification
Directed full-scale, zero-scale and near-zero samples at gain 5 separate truncation toward zero from floor rounding: 16'h0001 must give 16'h4001, not 16'h4000. Mid-scale inputs and gain 0 show whether the scaling is centred correctly. A sweep of every digit above 9 checks the clamp. Distinct per-channel values expose swapped lanes, and a sweep of the attenuation digit with the data fixed shows that the digit drives only the addresses. Long random streams with gaps in the valid strobe and random digits check the two-cycle timing and show that the output holds between valid samples.

// File: rtl/amp_scaler_pkg.sv
`timescale 1ns/1ps
package amp_scaler_pkg;
  localparam int unsigned ATTEN_SEL_W = 3;

  function automatic int unsigned clamp_u(input int unsigned v, input int unsigned lim);
    return (v > lim) ? lim : v;
  endfunction

  function automatic int unsigned width_for(input int unsigned max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction
endpackage

// File: rtl/amp_gain_clamp.sv
`timescale 1ns/1ps
module amp_gain_clamp #(
  parameter int unsigned CODE_W   = 4,
  parameter int unsigned MAX_GAIN = 9,
  parameter int unsigned GAIN_W   = amp_scaler_pkg::width_for(MAX_GAIN)
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [GAIN_W-1:0] gain_o
);
  always_comb begin
    gain_o = GAIN_W'(amp_scaler_pkg::clamp_u(int'(unsigned'(code_i)), MAX_GAIN));
  end
endmodule

// File: rtl/amp_sample_scaler.sv
`timescale 1ns/1ps
module amp_sample_scaler #(
  parameter int unsigned SAMPLE_W = 16,
  parameter int unsigned GAIN_W   = 4,
  parameter int unsigned DIVISOR  = 10
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ld1_i,
  input  logic                ld2_i,
  input  logic [GAIN_W-1:0]   gain_i,
  input  logic [SAMPLE_W-1:0] data_i,
  output logic [SAMPLE_W-1:0] data_o
);
  localparam int unsigned PROD_W = SAMPLE_W + GAIN_W + 1;
  localparam logic signed [PROD_W-1:0] DIV_S   = PROD_W'(DIVISOR);
  localparam logic signed [PROD_W-1:0] POS_LIM = PROD_W'((64'd1 << (SAMPLE_W - 1)) - 64'd1);
  localparam logic signed [PROD_W-1:0] NEG_LIM = ~POS_LIM;
  localparam logic [SAMPLE_W-1:0]      MID     = SAMPLE_W'(64'd1 << (SAMPLE_W - 1));

  logic signed [SAMPLE_W-1:0] centred;
  logic signed [PROD_W-1:0]   s_ext, g_ext, prod_d, prod_q, quot;
  logic signed [SAMPLE_W-1:0] sat;
  logic [SAMPLE_W-1:0]        data_q;

  // offset binary -> two's complement about mid-scale
  assign centred = {~data_i[SAMPLE_W-1], data_i[SAMPLE_W-2:0]};
  assign s_ext   = {{(PROD_W-SAMPLE_W){centred[SAMPLE_W-1]}}, centred};
  assign g_ext   = {{(PROD_W-GAIN_W){1'b0}}, gain_i};
  assign prod_d  = s_ext * g_ext;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    prod_q <= '0;
    else if (ld1_i) prod_q <= prod_d;
  end

  // signed division truncates toward zero
  assign quot = prod_q / DIV_S;

  always_comb begin
    if (quot > POS_LIM)      sat = POS_LIM[SAMPLE_W-1:0];
    else if (quot < NEG_LIM) sat = NEG_LIM[SAMPLE_W-1:0];
    else                     sat = quot[SAMPLE_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    data_q <= MID;
    else if (ld2_i) data_q <= {~sat[SAMPLE_W-1], sat[SAMPLE_W-2:0]};
  end

  assign data_o = data_q;
endmodule

// File: rtl/amp_atten_sel.sv
`timescale 1ns/1ps
module amp_atten_sel #(
  parameter int unsigned NUM_CH   = 4,
  parameter int unsigned CODE_W   = 4,
  parameter int unsigned SEL_W    = amp_scaler_pkg::ATTEN_SEL_W,
  parameter int unsigned MAX_STEP = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [CODE_W-1:0]       code_i,
  output logic [NUM_CH*SEL_W-1:0] sel_o
);
  localparam int unsigned SEL_MAX = (1 << SEL_W) - 1;

  int unsigned step;
  always_comb step = amp_scaler_pkg::clamp_u(int'(unsigned'(code_i)), MAX_STEP);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic [SEL_W-1:0] sel_d, sel_q;
    always_comb sel_d = SEL_W'(amp_scaler_pkg::clamp_u(ch * step, SEL_MAX));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sel_q <= '0;
      else         sel_q <= sel_d;
    end
    assign sel_o[ch*SEL_W +: SEL_W] = sel_q;
  end
endmodule

// File: rtl/chan_gain_scaler.sv
`timescale 1ns/1ps
module chan_gain_scaler #(
  parameter int unsigned NUM_CH   = 4,
  parameter int unsigned SAMPLE_W = 16,
  parameter int unsigned CODE_W   = 4,
  parameter int unsigned MAX_GAIN = 9,
  parameter int unsigned DIVISOR  = 10,
  parameter int unsigned MAX_STEP = 2,
  parameter int unsigned SEL_W    = amp_scaler_pkg::ATTEN_SEL_W
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       smp_valid_i,
  input  logic [NUM_CH*SAMPLE_W-1:0] smp_data_i,
  input  logic [CODE_W-1:0]          gain_bcd_i,
  input  logic [CODE_W-1:0]          atten_bcd_i,
  output logic                       smp_valid_o,
  output logic [NUM_CH*SAMPLE_W-1:0] smp_data_o,
  output logic [NUM_CH*SEL_W-1:0]    atten_sel_o
);
  localparam int unsigned GAIN_W = amp_scaler_pkg::width_for(MAX_GAIN);

  logic [GAIN_W-1:0] gain;
  logic              v1_q, v2_q;

  amp_gain_clamp #(.CODE_W(CODE_W), .MAX_GAIN(MAX_GAIN), .GAIN_W(GAIN_W)) u_gain (
    .code_i(gain_bcd_i),
    .gain_o(gain)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1_q <= 1'b0;
      v2_q <= 1'b0;
    end else begin
      v1_q <= smp_valid_i;
      v2_q <= v1_q;
    end
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_lane
    amp_sample_scaler #(.SAMPLE_W(SAMPLE_W), .GAIN_W(GAIN_W), .DIVISOR(DIVISOR)) u_scl (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .ld1_i (smp_valid_i),
      .ld2_i (v1_q),
      .gain_i(gain),
      .data_i(smp_data_i[ch*SAMPLE_W +: SAMPLE_W]),
      .data_o(smp_data_o[ch*SAMPLE_W +: SAMPLE_W])
    );
  end

  amp_atten_sel #(.NUM_CH(NUM_CH), .CODE_W(CODE_W), .SEL_W(SEL_W), .MAX_STEP(MAX_STEP)) u_atten (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .code_i(atten_bcd_i),
    .sel_o (atten_sel_o)
  );

  assign smp_valid_o = v2_q;
endmodule

// File: rtl/chan_gain_scaler_chk.sv
`timescale 1ns/1ps
module chan_gain_scaler_chk #(
  parameter int unsigned NUM_CH   = 4,
  parameter int unsigned SAMPLE_W = 16,
  parameter int unsigned CODE_W   = 4,
  parameter int unsigned MAX_STEP = 2,
  parameter int unsigned SEL_W    = 3
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       smp_valid_i,
  input logic [CODE_W-1:0]          gain_bcd_i,
  input logic [CODE_W-1:0]          atten_bcd_i,
  input logic                       smp_valid_o,
  input logic [NUM_CH*SAMPLE_W-1:0] smp_data_o,
  input logic [NUM_CH*SEL_W-1:0]    atten_sel_o
);
  localparam logic [SAMPLE_W-1:0] MID = SAMPLE_W'(64'd1 << (SAMPLE_W - 1));

  p_lat_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_valid_i |-> ##2 smp_valid_o);

  p_lat_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_valid_i |-> ##2 !smp_valid_o);

  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_valid_o |-> $stable(smp_data_o));

  p_zero_gain_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_i && gain_bcd_i == '0) |-> ##2 (smp_data_o[SAMPLE_W-1:0] == MID));

  if (NUM_CH > 1) begin : g_step
    p_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> (int'(unsigned'(atten_sel_o[2*SEL_W-1:SEL_W])) ==
                ((int'(unsigned'($past(atten_bcd_i))) > int'(MAX_STEP)) ?
                  int'(MAX_STEP) : int'(unsigned'($past(atten_bcd_i))))));
  end

  for (genvar ch = 1; ch < NUM_CH; ch++) begin : g_mono
    p_mono_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      atten_sel_o[ch*SEL_W +: SEL_W] >= atten_sel_o[(ch-1)*SEL_W +: SEL_W]);
  end
endmodule

bind chan_gain_scaler chan_gain_scaler_chk #(
  .NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W), .CODE_W(CODE_W), .MAX_STEP(MAX_STEP), .SEL_W(SEL_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .smp_valid_i(smp_valid_i), .gain_bcd_i(gain_bcd_i),
  .atten_bcd_i(atten_bcd_i), .smp_valid_o(smp_valid_o), .smp_data_o(smp_data_o),
  .atten_sel_o(atten_sel_o)
);

// File: tb/chan_gain_scaler_test.sv
`timescale 1ns/1ps
module chan_gain_scaler_test;
  localparam int NCH = 4;
  localparam int SW  = 16;
  localparam int DW  = NCH * SW;
  localparam int AW  = NCH * 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          vin = 1'b0;
  logic [DW-1:0] din = '0;
  logic [3:0]    gain = '0;
  logic [3:0]    atten = '0;
  logic          vout;
  logic [DW-1:0] dout;
  logic [AW-1:0] asel;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  chan_gain_scaler uut (
    .clk_i(clk), .rst_ni(rst_n), .smp_valid_i(vin), .smp_data_i(din),
    .gain_bcd_i(gain), .atten_bcd_i(atten), .smp_valid_o(vout),
    .smp_data_o(dout), .atten_sel_o(asel)
  );

  function automatic logic [15:0] model_scale(input logic [15:0] x, input logic [3:0] g);
    int s, gg, q;
    s  = int'(x) - 32768;
    gg = (g > 9) ? 9 : int'(g);
    q  = (s * gg) / 10;
    if (q > 32767) q = 32767;
    if (q < -32768) q = -32768;
    return 16'(q + 32768);
  endfunction

  function automatic logic [AW-1:0] model_sel(input logic [3:0] b);
    logic [AW-1:0] r;
    int st, c;
    st = (b > 2) ? 2 : int'(b);
    for (int k = 0; k < NCH; k++) begin
      c = k * st;
      r[k*3 +: 3] = 3'((c > 7) ? 7 : c);
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // expected pipeline: d1 = inputs of previous cycle, d2 = two cycles back
  logic          d1_v = 0, d2_v = 0;
  logic [DW-1:0] d1_d = '0, d2_d = '0;
  string         d1_t = "R2", d2_t = "R2";
  logic [DW-1:0] last_d = {NCH{16'h8000}};
  logic [3:0]    prev_atten = '0;

  task automatic tick(input logic v, input logic [DW-1:0] d, input logic [3:0] g,
                      input logic [3:0] a, input string tag);
    @(negedge clk);
    check("R4 valid", 64'(vout), 64'(d2_v));
    if (d2_v) begin
      last_d = d2_d;
      check(d2_t, 64'(dout), 64'(last_d));
    end else begin
      check("R6 hold", 64'(dout), 64'(last_d));
    end
    check("R7 atten", 64'(asel), 64'(model_sel(prev_atten)));
    d2_v = d1_v; d2_d = d1_d; d2_t = d1_t;
    vin = v; din = d; gain = g; atten = a;
    prev_atten = a;
    d1_v = v;
    for (int k = 0; k < NCH; k++) d1_d[k*SW +: SW] = model_scale(d[k*SW +: SW], g);
    d1_t = (g > 9) ? "R3 clamp" : tag;
  endtask

  initial begin
    #800000;
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] rd;
    void'($urandom(1234));
    repeat (3) @(negedge clk);
    check("R1 valid", 64'(vout), 64'd0);
    check("R1 data", 64'(dout), {NCH{16'h8000}});
    check("R1 atten", 64'(asel), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // rounding toward zero and full-scale at gain 5
    tick(1, {16'h8000, 16'h0001, 16'h0000, 16'hFFFF}, 4'd5, 4'd0, "R2 gain5");
    tick(1, {16'h8001, 16'h7FFF, 16'hC000, 16'h4000}, 4'd5, 4'd1, "R2 gain5b");
    tick(1, {16'hFFFF, 16'h0000, 16'h1234, 16'hFFFF}, 4'd9, 4'd2, "R2 gain9");
    // mid-scale input and zero gain
    tick(1, {NCH{16'h8000}}, 4'd7, 4'd0, "R5 mid");
    tick(1, {16'hFFFF, 16'h0000, 16'h0001, 16'hABCD}, 4'd0, 4'd0, "R5 zero");
    // gaps
    tick(0, '0, 4'd3, 4'd0, "R6");
    tick(0, {NCH{16'h1111}}, 4'd9, 4'd0, "R6");
    tick(0, '0, 4'd0, 4'd0, "R6");
    // clamp of digits above 9
    for (int g = 10; g < 16; g++) tick(1, {16'h0000, 16'hFFFF, 16'h0001, 16'h7FFF}, 4'(g), 4'd0, "R3");
    // lane independence
    tick(1, {16'h8000, 16'h8000, 16'h8000, 16'hFFFF}, 4'd8, 4'd0, "R9 lane0");
    tick(1, {16'h8000, 16'h0000, 16'h8000, 16'h8000}, 4'd8, 4'd0, "R9 lane2");
    tick(1, {16'h0123, 16'h4567, 16'h89AB, 16'hCDEF}, 4'd6, 4'd0, "R9 mix");
    // attenuation digit sweep with fixed data
    for (int a = 0; a < 16; a++) tick(1, {16'h0123, 16'hF00D, 16'h7FFF, 16'hE001}, 4'd4, 4'(a), "R8 atten_indep");
    for (int a = 15; a >= 0; a--) tick(a[0], {16'h0123, 16'hF00D, 16'h7FFF, 16'hE001}, 4'd4, 4'(a), "R8 atten_indep");

    // random streams
    for (int i = 0; i < 3000; i++) begin
      for (int k = 0; k < NCH; k++) rd[k*SW +: SW] = 16'($urandom);
      tick(($urandom % 10) < 7, rd, 4'($urandom), 4'($urandom), "R2 random");
    end
    repeat (3) tick(0, '0, 4'd0, 4'd0, "R6");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule